// File: doc/BRIEF.md
# Phase Population Detector and Set-Pulse Interleaver

This block runs in the control logic of a multiphase buck controller with up to three phases. After the controller is enabled, it uses a short probing window to find out which of the phase-2 and phase-3 output pins are strapped to the supply. A strapped pin means that phase is not fitted. From the result it derives the number of phases in use and a mask of the fitted phases.

Once detection is complete, the block hands out PWM set pulses on master clock ticks. The pulses rotate through the fitted phases, so each phase runs at the master rate divided by the phase count. When the system asks to shed phases, only phase 1 keeps receiving pulses, still at the divided rate. When multiphase operation returns, the rotation starts again at phase 1.

The block also produces a level that allows the phase-2 and phase-3 drivers to run, and a high-impedance enable for pins that are not fitted. The analog pin sinking, the comparators and the PWM reset path are outside this block. Their results arrive here as sampled digital levels.

Top module: `phase_interleaver`

## Requirements
- R1: While reset is high or `en_i` is low, every output is zero: `ph_en_o`, `set_o`, `pin_hiz_o`, `det_done_o`, `probe_sink_o` and `drv23_on_o`.
- R2: The probe window opens in the cycle after `en_i` is seen high, and `probe_sink_o` is high throughout it. The window covers exactly three `tick_i` cycles. `det_done_o` pulses for a single cycle in the clock cycle after the third tick, and `probe_sink_o` falls at the same time.
- R3: The mask is decoded from the probe results. Bit k of `ph_en_o` stands for phase k+1, and bit 0 is always set.
  - Only phase 3 read high: the mask is 3'b011.
  - Both phase 2 and phase 3 read high: the mask is 3'b001.
  - Any other combination: the mask is 3'b111, and this includes phase 2 alone reading high.
  - A pin counts as high if it reads high on any one of the three tick cycles.
- R4: After detection, `pin_hiz_o` equals the inverse of the mask, with bit 0 held at 0. The mask and `pin_hiz_o` then ignore any later change on `p2_hi_i` and `p3_hi_i` until `en_i` falls.
- R5: After detection, each `tick_i` produces a one-cycle pulse on exactly one bit of `set_o`, visible in the following cycle. The pulses rotate phase 1, 2, 3 over the fitted phases only, and the first pulse goes to phase 1. Each phase is therefore pulsed once every N ticks, where N is the phase count.
- R6: While `shed_i` is high, only phase 1 receives pulses, and it receives them at the same one-in-N tick rate.
- R7: After `shed_i` falls, the first tick pulses phase 1, and the rotation then continues with phase 2.
- R8: `drv23_on_o` is high only after detection, with `en_i` high, N greater than 1 and `shed_i` low.
- R9: When `en_i` falls, the block returns to the idle state one cycle later and the mask is cleared. Raising `en_i` again starts a new detection.
- R10: No `set_o` pulse is produced while the block is disabled or still probing, whatever `tick_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Controller enable |
| tick_i | input | 1 | Master clock tick, one cycle wide |
| p2_hi_i | input | 1 | Sampled phase-2 pin comparator, 1 = pin pulled high |
| p3_hi_i | input | 1 | Sampled phase-3 pin comparator, 1 = pin pulled high |
| shed_i | input | 1 | Request for single-phase operation |
| ph_en_o | output | 3 | Mask of fitted phases, bit k = phase k+1 |
| set_o | output | 3 | PWM set pulses, bit k = phase k+1 |
| pin_hiz_o | output | 3 | High-impedance enable for unfitted pins |
| det_done_o | output | 1 | One-cycle strobe at the end of detection |
| probe_sink_o | output | 1 | Probe sink active during the detection window |
| drv23_on_o | output | 1 | Allows the phase-2 and phase-3 drivers to run |

## Verification
Detection is tried with all four strap combinations, followed by rotation checks against the expected order. These runs separate the 2-phase decode from the 1-phase decode. The phase-2-only strap shows that it falls back to three phases rather than being treated as a disabled phase 2. A strap seen on only the middle tick of the window shows that one high sample is enough. A shed sequence is entered mid-rotation, and separate checks confirm that:
- phase 1 keeps the divided rate during shedding;
- the rotation restarts at phase 1 afterwards;
- strap changes after detection and ticks while disabled have no effect.

// File: rtl/phil_pkg.sv
package phil_pkg;

    localparam int NUM_PH    = 3;
    localparam int PH_CNT_W  = $clog2(NUM_PH + 1);
    localparam int SLOT_W    = $clog2(NUM_PH);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_RUN    = 2'd2
    } ctl_state_e;

    typedef logic [NUM_PH-1:0] ph_vec_t;

    // strap decode: only the combination "phase 3 high" drops phase 3,
    // "phase 2 and 3 high" drops both; phase 2 alone high keeps all three
    function automatic ph_vec_t strap_to_mask(input logic p2_hi, input logic p3_hi);
        ph_vec_t m;
        if (p3_hi && p2_hi)      m = 3'b001;
        else if (p3_hi)          m = 3'b011;
        else                     m = 3'b111;
        return m;
    endfunction

    function automatic logic [PH_CNT_W-1:0] mask_count(input ph_vec_t m);
        logic [PH_CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < NUM_PH; i++) c = c + PH_CNT_W'(m[i]);
        return c;
    endfunction

endpackage

// File: rtl/strap_probe.sv
module strap_probe
    import phil_pkg::*;
#(
    parameter int WIN_TICKS = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_i,
    input  logic     tick_i,
    input  logic     p2_hi_i,
    input  logic     p3_hi_i,
    output logic     run_o,
    output logic     probing_o,
    output logic     done_o,
    output ph_vec_t  mask_o
);
    localparam int CW = $clog2(WIN_TICKS + 1);

    ctl_state_e       state;
    logic [CW-1:0]    tcnt;
    logic [1:0]       seen_hi;
    logic [1:0]       seen_nx;

    assign seen_nx = seen_hi | {p3_hi_i, p2_hi_i};

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state   <= ST_IDLE;
            tcnt    <= '0;
            seen_hi <= '0;
            done_o  <= 1'b0;
            mask_o  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    state   <= ST_PROBE;
                    tcnt    <= '0;
                    seen_hi <= '0;
                end
                ST_PROBE: begin
                    if (tick_i) begin
                        seen_hi <= seen_nx;
                        tcnt    <= tcnt + 1'b1;
                        if (tcnt == CW'(WIN_TICKS - 1)) begin
                            state  <= ST_RUN;
                            done_o <= 1'b1;
                            mask_o <= strap_to_mask(seen_nx[0], seen_nx[1]);
                        end
                    end
                end
                ST_RUN:  state <= ST_RUN;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run_o     = (state == ST_RUN);
    assign probing_o = (state == ST_PROBE);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_enters_run_R2: assert property (@(posedge clk) disable iff (rst)
        (done_o && en_i) |-> run_o);
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (run_o && en_i) |=> $stable(mask_o));
    assert_phase1_fitted_R3: assert property (@(posedge clk) disable iff (rst)
        run_o |-> mask_o[0]);
endmodule

// File: rtl/slot_rotor.sv
module slot_rotor
    import phil_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_i,
    input  logic                 tick_i,
    input  logic                 shed_i,
    input  logic [PH_CNT_W-1:0]  nph_i,
    output ph_vec_t              set_o
);
    logic [SLOT_W-1:0] slot;
    logic              resume;
    logic              last_slot;

    assign last_slot = (PH_CNT_W'(slot) == nph_i - PH_CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            slot   <= '0;
            resume <= 1'b0;
            set_o  <= '0;
        end else begin
            set_o <= '0;
            if (shed_i) resume <= 1'b1;
            if (tick_i) begin
                if (resume && !shed_i) begin
                    set_o  <= 3'b001;
                    slot   <= (nph_i == PH_CNT_W'(1)) ? '0 : SLOT_W'(1);
                    resume <= 1'b0;
                end else begin
                    if (!shed_i || slot == '0) set_o <= ph_vec_t'(3'b001 << slot);
                    slot <= last_slot ? '0 : slot + 1'b1;
                end
            end
        end
    end

    assert_set_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_o));
    assert_set_needs_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (!tick_i) |=> (set_o == '0));
    assert_shed_phase1_only_R6: assert property (@(posedge clk) disable iff (rst)
        (run_i && shed_i) |=> (set_o[2:1] == 2'b00));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!run_i) |=> (set_o == '0));
endmodule

// File: rtl/phase_interleaver.sv
module phase_interleaver
    import phil_pkg::*;
#(
    parameter int WIN_TICKS = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_i,
    input  logic        tick_i,
    input  logic        p2_hi_i,
    input  logic        p3_hi_i,
    input  logic        shed_i,
    output logic [2:0]  ph_en_o,
    output logic [2:0]  set_o,
    output logic [2:0]  pin_hiz_o,
    output logic        det_done_o,
    output logic        probe_sink_o,
    output logic        drv23_on_o
);
    logic                 running;
    ph_vec_t              mask;
    ph_vec_t              pulses;
    logic [PH_CNT_W-1:0]  nph;

    strap_probe #(.WIN_TICKS(WIN_TICKS)) u_probe (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .tick_i    (tick_i),
        .p2_hi_i   (p2_hi_i),
        .p3_hi_i   (p3_hi_i),
        .run_o     (running),
        .probing_o (probe_sink_o),
        .done_o    (det_done_o),
        .mask_o    (mask)
    );

    assign nph = mask_count(mask);

    slot_rotor u_rotor (
        .clk    (clk),
        .rst    (rst),
        .run_i  (running && en_i),
        .tick_i (tick_i),
        .shed_i (shed_i),
        .nph_i  (nph),
        .set_o  (pulses)
    );

    assign ph_en_o    = mask;
    assign set_o      = pulses;
    assign pin_hiz_o  = running ? {~mask[2:1], 1'b0} : 3'b000;
    assign drv23_on_o = running && en_i && !shed_i && (nph > PH_CNT_W'(1));

    assert_set_in_mask_R5: assert property (@(posedge clk) disable iff (rst)
        ((set_o & ~ph_en_o) == 3'b000));
    assert_drv_multi_R8: assert property (@(posedge clk) disable iff (rst)
        drv23_on_o |-> ph_en_o[1]);
    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (!en_i) |=> (ph_en_o == 3'b000 && !probe_sink_o));
    assert_probe_no_hiz_R4: assert property (@(posedge clk) disable iff (rst)
        probe_sink_o |-> (pin_hiz_o == 3'b000));
endmodule

// File: tb/tb_phase_interleaver.sv
module tb_phase_interleaver;
    logic clk = 1'b0;
    logic rst, en_i, tick_i, p2_hi_i, p3_hi_i, shed_i;
    logic [2:0] ph_en_o, set_o, pin_hiz_o;
    logic det_done_o, probe_sink_o, drv23_on_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    phase_interleaver dut (
        .clk(clk), .rst(rst), .en_i(en_i), .tick_i(tick_i),
        .p2_hi_i(p2_hi_i), .p3_hi_i(p3_hi_i), .shed_i(shed_i),
        .ph_en_o(ph_en_o), .set_o(set_o), .pin_hiz_o(pin_hiz_o),
        .det_done_o(det_done_o), .probe_sink_o(probe_sink_o),
        .drv23_on_o(drv23_on_o)
    );

    // strap vectors: {p2, p3, expected mask}
    typedef struct packed {
        logic       p2;
        logic       p3;
        logic [2:0] mask;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{1'b0, 1'b0, 3'b111},
        '{1'b0, 1'b1, 3'b011},
        '{1'b1, 1'b1, 3'b001},
        '{1'b1, 1'b0, 3'b111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive inputs, take one edge, settle to sample point
    task automatic cyc(input logic t);
        tick_i = t;
        @(posedge clk);
        #2;
    endtask

    task automatic start_detect(input logic p2, input logic p3);
        en_i = 1'b0;
        cyc(0);
        en_i = 1'b1;
        p2_hi_i = p2;
        p3_hi_i = p3;
        cyc(0);
        for (int i = 0; i < 3; i++) cyc(1);
        p2_hi_i = 1'b0;
        p3_hi_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en_i = 1'b0; tick_i = 1'b0; p2_hi_i = 1'b0; p3_hi_i = 1'b0; shed_i = 1'b0;
        cyc(0); cyc(1);
        // R1 reset state
        chk("R1 mask", ph_en_o, 0);
        chk("R1 set", set_o, 0);
        chk("R1 hiz", pin_hiz_o, 0);
        chk("R1 done", det_done_o, 0);
        chk("R1 sink", probe_sink_o, 0);
        chk("R1 drv", drv23_on_o, 0);
        rst = 1'b0;
        cyc(1);
        chk("R10 idle tick", set_o, 0);

        // R2 window timing
        en_i = 1'b1;
        cyc(0);
        chk("R2 sink up", probe_sink_o, 1);
        cyc(1);
        chk("R10 probe tick", set_o, 0);
        cyc(0);
        cyc(1);
        chk("R2 not done after 2", det_done_o, 0);
        chk("R2 sink held", probe_sink_o, 1);
        cyc(1);
        chk("R2 done strobe", det_done_o, 1);
        chk("R2 sink down", probe_sink_o, 0);
        cyc(0);
        chk("R2 done single", det_done_o, 0);

        // main loop over strap patterns
        for (int v = 0; v < 4; v++) begin
            int n;
            start_detect(VECS[v].p2, VECS[v].p3);
            chk("R3 mask", ph_en_o, VECS[v].mask);
            chk("R4 hiz", pin_hiz_o, {~VECS[v].mask[2:1], 1'b0});
            n = $countones(VECS[v].mask);
            chk("R8 drv", drv23_on_o, (n > 1) ? 1 : 0);
            for (int k = 0; k < 7; k++) begin
                cyc(1);
                chk("R5 rotation", set_o, 3'b001 << (k % n));
            end
            cyc(0);
            chk("R5 no tick no pulse", set_o, 0);
        end

        // R3 single high sample in middle of window
        en_i = 1'b0; cyc(0);
        en_i = 1'b1; cyc(0);
        cyc(1);
        p3_hi_i = 1'b1; cyc(1);
        p3_hi_i = 1'b0; cyc(1);
        chk("R3 one sample", ph_en_o, 3'b011);

        // R4 straps ignored after detection
        p2_hi_i = 1'b1; p3_hi_i = 1'b1;
        cyc(1); cyc(1);
        chk("R4 mask hold", ph_en_o, 3'b011);
        chk("R4 hiz hold", pin_hiz_o, 3'b100);
        p2_hi_i = 1'b0; p3_hi_i = 1'b0;

        // R6/R7 shedding with three phases
        start_detect(0, 0);
        cyc(1); chk("R5 first", set_o, 3'b001);
        cyc(1); chk("R5 second", set_o, 3'b010);
        shed_i = 1'b1;
        cyc(1); chk("R6 slot3 quiet", set_o, 3'b000);
        chk("R8 drv shed", drv23_on_o, 0);
        cyc(1); chk("R6 phase1", set_o, 3'b001);
        cyc(1); chk("R6 gap a", set_o, 3'b000);
        cyc(1); chk("R6 gap b", set_o, 3'b000);
        cyc(1); chk("R6 phase1 again", set_o, 3'b001);
        cyc(1); chk("R6 gap c", set_o, 3'b000);
        shed_i = 1'b0;
        cyc(0); chk("R8 drv back", drv23_on_o, 1);
        cyc(1); chk("R7 resume phase1", set_o, 3'b001);
        cyc(1); chk("R7 then phase2", set_o, 3'b010);
        cyc(1); chk("R7 then phase3", set_o, 3'b100);

        // R9 disable clears, R10 no pulses
        en_i = 1'b0;
        cyc(1);
        chk("R9 mask clear", ph_en_o, 0);
        chk("R9 drv low", drv23_on_o, 0);
        chk("R9 hiz clear", pin_hiz_o, 0);
        cyc(1);
        chk("R10 disabled tick", set_o, 0);
        start_detect(1, 1);
        chk("R9 redetect", ph_en_o, 3'b001);
        chk("R8 single drv", drv23_on_o, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule